// File: doc/BRIEF.md
# Deferred Condition Flag Resolver

This block turns a recorded arithmetic or logical operation kind and two saved 32-bit words into the four condition flags: negative (N), zero (Z), overflow (V) and carry (C). An execution pipeline that does not compute flags eagerly records three things: the kind of operation, the result word, and one operand. When a later instruction needs the flags, it raises a request, and this block rebuilds them.

For subtraction-type operations, the block first recomputes the minuend from the difference and the subtrahend. It then derives carry and overflow from that minuend. The extended add and subtract forms chain across multi-word arithmetic. For these forms a zero result keeps the earlier Z value, and only a nonzero result can clear it.

The resolved flags sit in a 5-bit register. The register changes only on a request that carries a legal operation code. An illegal code causes a one-cycle error pulse and leaves the register as it was.

Top module: `cc_resolver`

## Requirements
- R1: After reset is released, `flags_o` is 5'b00000 and `err_o` is 0.
- R2: Flag vector layout is bit0 C, bit1 V, bit2 Z, bit3 N, bit4 reserved (0 except in passthrough). Operation codes are: 0 passthrough, 1 logic, 2 add, 3 subtract, 4 byte compare, 5 word compare, 6 add-extended, 7 subtract-extended, 8 shift. In passthrough, `flags_o` becomes `dst_i[4:0]` one cycle after the request.
- R3: Logic (code 1) sets Z when dst is zero, sets N when dst is nonzero with bit 31 set, and clears V and C. The src word has no effect.
- R4: Add (code 2), with dst as the sum and src as the addend:
  - C = (dst < src), unsigned.
  - V = bit31 of (src^dst) & ~((dst-src)^src).
  - N and Z come from dst.
- R5: Subtract (code 3), with dst as the difference:
  - The minuend m is rebuilt as dst+src.
  - C = (m < src), unsigned.
  - V = bit31 of (m^dst)&(m^src).
  - N and Z come from dst. The previous Z has no effect.
- R6: Byte compare (code 4) and word compare (code 5) apply the R5 rule to the low 8 or 16 bits. N is taken from bit 7 or bit 15. The upper bits of both words have no effect.
- R7: Add-extended (code 6):
  - C = (dst <= src), unsigned.
  - V = bit31 of (src^dst) & ~((dst-src-1)^src).
- R8: Subtract-extended (code 7):
  - m = dst+src+1.
  - C = (m <= src), unsigned.
  - V = bit31 of (m^dst)&(m^src).
- R9: For codes 6 and 7, Z = (dst==0) AND `prev_z_i`.
- R10: Shift (code 8): N and Z come from dst, C = (src != 0), and V = 0.
- R11: A request with code 9..15 drives `err_o` high for exactly the next cycle and leaves `flags_o` unchanged.
- R12: Without a request, `flags_o` holds and `err_o` is 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Resolve request strobe |
| op_i | input | 4 | Recorded operation code |
| src_i | input | 32 | Saved operand word |
| dst_i | input | 32 | Saved result word, or the flag vector in passthrough |
| prev_z_i | input | 1 | Z flag before the extended operation |
| flags_o | output | 5 | Resolved flags {rsv, N, Z, V, C} |
| err_o | output | 1 | One-cycle pulse for an illegal operation code |

## Verification
A wrong minuend rebuild or a wrong compare width shows up in `flags_o` on the cycle after the request as a wrong C or V. Compare vectors whose upper bits disagree with the low bits expose any leak across the truncation boundary. A broken extended-Z chain shows only when `prev_z_i` is low with a zero result, so both polarities are applied. A register that updates on an illegal code or without a request shows as `flags_o` drifting away from the last good value one cycle later.

// File: rtl/cc_resolver_pkg.sv
package cc_resolver_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned FLAG_W = 5;

  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_V = 1;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_N = 3;

  typedef enum logic [OP_W-1:0] {
    OP_PASS  = 4'd0,
    OP_LOGIC = 4'd1,
    OP_ADD   = 4'd2,
    OP_SUB   = 4'd3,
    OP_CMPB  = 4'd4,
    OP_CMPW  = 4'd5,
    OP_ADDX  = 4'd6,
    OP_SUBX  = 4'd7,
    OP_SHIFT = 4'd8
  } cc_op_e;

  typedef struct packed {
    logic rsv;
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_flags_t;
endpackage

// File: rtl/cc_nz.sv
module cc_nz #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val_i,
  output logic         n_o,
  output logic         z_o
);
  assign z_o = (val_i == '0);
  assign n_o = !z_o && val_i[W-1];
endmodule

// File: rtl/cc_sub_flags.sv
module cc_sub_flags #(
  parameter int unsigned W   = 32,
  parameter bit          EXT = 1'b0
) (
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  output logic         n_o,
  output logic         z_o,
  output logic         v_o,
  output logic         c_o
);
  logic [W-1:0] minuend;
  logic [W-1:0] ovf_vec;

  // recover the minuend from difference and subtrahend
  assign minuend = dst_i + src_i + {{(W-1){1'b0}}, EXT};
  assign ovf_vec = (minuend ^ dst_i) & (minuend ^ src_i);
  assign v_o     = ovf_vec[W-1];

  generate
    if (EXT) begin : g_ext
      assign c_o = (minuend <= src_i);
    end else begin : g_plain
      assign c_o = (minuend < src_i);
    end
  endgenerate

  cc_nz #(.W(W)) nz_i (
    .val_i(dst_i),
    .n_o  (n_o),
    .z_o  (z_o)
  );
endmodule

// File: rtl/cc_add_flags.sv
module cc_add_flags #(
  parameter int unsigned W   = 32,
  parameter bit          EXT = 1'b0
) (
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  output logic         v_o,
  output logic         c_o
);
  logic [W-1:0] other;
  logic [W-1:0] ovf_vec;

  // rebuild the first addend
  assign other   = dst_i - src_i - {{(W-1){1'b0}}, EXT};
  assign ovf_vec = (src_i ^ dst_i) & ~(other ^ src_i);
  assign v_o     = ovf_vec[W-1];

  generate
    if (EXT) begin : g_ext
      assign c_o = (dst_i <= src_i);
    end else begin : g_plain
      assign c_o = (dst_i < src_i);
    end
  endgenerate
endmodule

// File: rtl/cc_resolver.sv
module cc_resolver
  import cc_resolver_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DW-1:0]     src_i,
  input  logic [DW-1:0]     dst_i,
  input  logic              prev_z_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              err_o
);
  localparam int unsigned N_SUB = 4;  // 0: full, 1: byte, 2: word, 3: full extended
  localparam int unsigned N_ADD = 2;  // 0: plain, 1: extended

  logic [N_SUB-1:0] sub_n, sub_z, sub_v, sub_c;
  logic [N_ADD-1:0] add_v, add_c;
  logic             res_n, res_z;
  logic             legal;
  cc_flags_t        flags_d, flags_q;
  logic             err_q;

  cc_nz #(.W(DW)) res_nz_i (
    .val_i(dst_i),
    .n_o  (res_n),
    .z_o  (res_z)
  );

  generate
    for (genvar g = 0; g < N_SUB; g++) begin : g_sub
      localparam int unsigned SW  = (g == 1) ? 8 : (g == 2) ? 16 : DW;
      localparam bit          SEX = (g == 3);
      cc_sub_flags #(.W(SW), .EXT(SEX)) sub_i (
        .dst_i(dst_i[SW-1:0]),
        .src_i(src_i[SW-1:0]),
        .n_o  (sub_n[g]),
        .z_o  (sub_z[g]),
        .v_o  (sub_v[g]),
        .c_o  (sub_c[g])
      );
    end
    for (genvar e = 0; e < N_ADD; e++) begin : g_add
      cc_add_flags #(.W(DW), .EXT(e == 1)) add_i (
        .dst_i(dst_i),
        .src_i(src_i),
        .v_o  (add_v[e]),
        .c_o  (add_c[e])
      );
    end
  endgenerate

  assign legal = (op_i <= OP_SHIFT);

  always_comb begin
    flags_d = '0;
    unique case (op_i)
      OP_PASS:  flags_d = cc_flags_t'(dst_i[FLAG_W-1:0]);
      OP_LOGIC: begin
        flags_d.n = res_n;
        flags_d.z = res_z;
      end
      OP_ADD: begin
        flags_d.n = res_n;
        flags_d.z = res_z;
        flags_d.v = add_v[0];
        flags_d.c = add_c[0];
      end
      OP_SUB: begin
        flags_d.n = sub_n[0];
        flags_d.z = sub_z[0];
        flags_d.v = sub_v[0];
        flags_d.c = sub_c[0];
      end
      OP_CMPB: begin
        flags_d.n = sub_n[1];
        flags_d.z = sub_z[1];
        flags_d.v = sub_v[1];
        flags_d.c = sub_c[1];
      end
      OP_CMPW: begin
        flags_d.n = sub_n[2];
        flags_d.z = sub_z[2];
        flags_d.v = sub_v[2];
        flags_d.c = sub_c[2];
      end
      OP_ADDX: begin
        flags_d.n = res_n;
        flags_d.z = res_z & prev_z_i;  // extended forms may only clear Z
        flags_d.v = add_v[1];
        flags_d.c = add_c[1];
      end
      OP_SUBX: begin
        flags_d.n = sub_n[3];
        flags_d.z = sub_z[3] & prev_z_i;
        flags_d.v = sub_v[3];
        flags_d.c = sub_c[3];
      end
      OP_SHIFT: begin
        flags_d.n = res_n;
        flags_d.z = res_z;
        flags_d.c = (src_i != '0);
      end
      default:  flags_d = flags_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= req_i && !legal;
      if (req_i && legal) flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;
  assign err_o   = err_q;

  assert_illegal_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (op_i > OP_SHIFT)) |=> (err_o && $stable(flags_o)));

  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!err_o && $stable(flags_o)));

  assert_ext_z_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !prev_z_i && (op_i == OP_ADDX || op_i == OP_SUBX)) |=> !flags_o[FLAG_Z]);

  assert_logic_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == OP_LOGIC) |=> (!flags_o[FLAG_V] && !flags_o[FLAG_C]));

  assert_nz_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i != OP_PASS && op_i <= OP_SHIFT) |=> !(flags_o[FLAG_N] && flags_o[FLAG_Z]));

  assert_shift_v_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == OP_SHIFT) |=> (!flags_o[FLAG_V] && (flags_o[FLAG_C] == $past(src_i != '0))));
endmodule

// File: tb/cc_resolver_tb_top.sv
module cc_resolver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 31;

  // vector table: op, src, dst, prev_z, expected flags {rsv,N,Z,V,C}
  localparam logic [3:0]  T_OP [NV] = '{
    4'd0, 4'd0,                         // R2
    4'd1, 4'd1, 4'd1,                   // R3
    4'd2, 4'd2, 4'd2, 4'd2,             // R4
    4'd3, 4'd3, 4'd3, 4'd3,             // R5
    4'd4, 4'd4, 4'd4, 4'd4,             // R6 byte
    4'd5, 4'd5, 4'd5,                   // R6 word
    4'd6, 4'd6, 4'd6, 4'd6,             // R7, R9
    4'd7, 4'd7, 4'd7, 4'd7,             // R8, R9
    4'd8, 4'd8, 4'd8                    // R10
  };
  localparam logic [31:0] T_SRC [NV] = '{
    32'h0, 32'hFFFF_FFFF,
    32'h1234, 32'h0, 32'h0,
    32'h3, 32'h1, 32'h2, 32'h1,
    32'h3, 32'h5, 32'h1, 32'h5,
    32'h1, 32'h10, 32'h1, 32'h1,
    32'h8000, 32'h1, 32'h1,
    32'h1, 32'h0, 32'h0, 32'h5,
    32'h2, 32'h0, 32'h0, 32'h0,
    32'h1, 32'h0, 32'h0
  };
  localparam logic [31:0] T_DST [NV] = '{
    32'h0000_001F, 32'hFFFF_FF0A,
    32'h0, 32'h8000_0000, 32'h12,
    32'h5, 32'h8000_0000, 32'h1, 32'h0,
    32'h2, 32'hFFFF_FFFE, 32'h7FFF_FFFF, 32'h0,
    32'hABCD_1280, 32'hFFFF_FF00, 32'hFF, 32'h7F,
    32'h1234_0000, 32'h7FFF, 32'hFFFF,
    32'h3, 32'h0, 32'h0, 32'h5,
    32'h2, 32'hFFFF_FFFF, 32'h0, 32'h0,
    32'h4000_0000, 32'h0, 32'h8000_0000
  };
  localparam logic T_PZ [NV] = '{
    1'b1, 1'b0,
    1'b0, 1'b1, 1'b1,
    1'b1, 1'b1, 1'b1, 1'b0,
    1'b1, 1'b1, 1'b1, 1'b0,
    1'b1, 1'b1, 1'b1, 1'b1,
    1'b1, 1'b1, 1'b1,
    1'b1, 1'b1, 1'b0, 1'b1,
    1'b1, 1'b1, 1'b1, 1'b0,
    1'b1, 1'b1, 1'b1
  };
  localparam logic [4:0] T_EXP [NV] = '{
    5'h1F, 5'h0A,
    5'h04, 5'h08, 5'h00,
    5'h00, 5'h0A, 5'h01, 5'h05,
    5'h00, 5'h09, 5'h02, 5'h04,
    5'h08, 5'h04, 5'h09, 5'h02,
    5'h04, 5'h02, 5'h09,
    5'h00, 5'h05, 5'h01, 5'h01,
    5'h00, 5'h09, 5'h04, 5'h00,
    5'h01, 5'h04, 5'h08
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] src = '0;
  logic [31:0] dst = '0;
  logic        prev_z = 1'b0;
  logic [4:0]  flags;
  logic        err;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_resolver dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_i   (req),
    .op_i    (op),
    .src_i   (src),
    .dst_i   (dst),
    .prev_z_i(prev_z),
    .flags_o (flags),
    .err_o   (err)
  );

  task automatic check(input string tag, input logic [4:0] got_f, input logic [4:0] exp_f,
                       input logic got_e, input logic exp_e);
    n_chk++;
    if (got_f !== exp_f || got_e !== exp_e) begin
      n_bad++;
      $display("FAIL %s: flags=%h err=%b expected flags=%h err=%b", tag, got_f, got_e, exp_f, exp_e);
    end
  endtask

  task automatic apply(input logic r, input logic [3:0] o, input logic [31:0] s,
                       input logic [31:0] d, input logic pz);
    @(negedge clk);
    req = r; op = o; src = s; dst = d; prev_z = pz;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", flags, 5'h00, err, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(1'b1, T_OP[i], T_SRC[i], T_DST[i], T_PZ[i]);
      check($sformatf("vector %0d op %0d (R2..R10)", i, T_OP[i]), flags, T_EXP[i], err, 1'b0);
    end

    // R11: illegal code keeps flags, pulses err once
    apply(1'b1, 4'd0, 32'h0, 32'h15, 1'b0);
    check("R2 passthrough before illegal", flags, 5'h15, err, 1'b0);
    apply(1'b1, 4'd9, 32'h0, 32'h0, 1'b1);
    check("R11 code 9 err pulse", flags, 5'h15, err, 1'b1);
    @(negedge clk);
    check("R11 pulse one cycle", flags, 5'h15, err, 1'b0);
    apply(1'b1, 4'd15, 32'h5, 32'h0, 1'b1);
    check("R11 code 15 err pulse", flags, 5'h15, err, 1'b1);

    // R12: no request, inputs change, nothing moves
    apply(1'b0, 4'd1, 32'h0, 32'h0, 1'b1);
    check("R12 idle logic zero", flags, 5'h15, err, 1'b0);
    apply(1'b0, 4'd9, 32'h0, 32'h0, 1'b1);
    check("R12 idle illegal", flags, 5'h15, err, 1'b0);

    // R6: upper bits of word compare ignored
    apply(1'b1, 4'd5, 32'hFFFF_0001, 32'h0000_FFFF, 1'b1);
    check("R6 word compare upper bits", flags, 5'h09, err, 1'b0);
    // R3: logic clears stale V/C
    apply(1'b1, 4'd1, 32'hFFFF_FFFF, 32'h1, 1'b0);
    check("R3 logic clears V C", flags, 5'h00, err, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule